// File: doc/BRIEF.md
# ADC Sequence Result Compare Unit

This block sits behind an analog-to-digital conversion sequencer that runs up to sixteen conversions per sequence. Each time the sequencer reports a finished conversion, it gives the position of that conversion within the sequence and its 12-bit result. The block then does one of two things. If automatic compare is off for that position, it stores the result in the position's result register and raises the position's flag. If compare is on, the result register holds a threshold that software loaded earlier. The new result is tested against that threshold, the threshold is left in place, and the flag is raised only when the test passes.

Software reaches the block through a small word-addressed register bus. Address 0 holds the per-position compare enables and address 1 the per-position operator bits. Address 2 is the read-only flag register. Address 3 is a write-only sequence-start control that wipes the flags. Addresses 16 to 31 are the result/threshold registers for positions 0 to 15. The flags are also driven straight out on a port for the logic around the block.

Top module: `adc_cmp_unit`

## Requirements
- R1: After synchronous reset, the enable register (address 0), the operator register (address 1), the flag register (address 2) and every result register read as zero.
- R2: A conversion on a position whose enable bit is 0 writes its result into that position's result register and sets that position's flag at the same clock edge.
- R3: A conversion on a position whose enable bit is 1 leaves that position's result register (the threshold) unchanged.
- R4: With enable 1 and operator bit 1, the flag is set when the result is strictly greater than the threshold.
- R5: With enable 1 and operator bit 0, the flag is set when the result is less than or equal to the threshold.
- R6: A compare that fails leaves the position's flag at its previous value.
- R7: Enable and operator bit n apply to the conversion reported with position index n, whatever analog channel it came from. Other positions are not affected.
- R8: A bus write to address 3 with bit 0 equal to 1 clears all sixteen flags. Bit 0 equal to 0 has no effect. A flag set by a conversion at the same edge survives the clear.
- R9: Bus writes to the flag register at address 2 have no effect on the flags.
- R10: bus_rdata shows, one clock edge later, the register at the address presented. Result registers read zero-extended to 16 bits. Addresses 3 to 15 read as zero. A result write keeps only wdata bits 11:0.
- R11: At a position with compare disabled, a conversion overrides a bus write to the same result register in the same cycle. At a position with compare enabled, the bus write takes effect, and the compare in that cycle uses the old threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a conversion has finished |
| conv_slot | input | 4 | Position of the finished conversion in the sequence |
| conv_data | input | 12 | Conversion result |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Registered read data for the address of the previous cycle |
| cmp_flags | output | 16 | Current per-position flags |

## Verification
A conversion strobe or register write sampled at a rising edge changes the flags and the result register at that same edge. So cmp_flags is due one edge after the stimulus, and bus_rdata shows the new stored value one further edge after the address is presented. The bench drives every input on the falling edge and samples at the next falling edge, which puts each check half a period after the edge that produced the value. The collision cases drive the strobe and the bus write in the same cycle to pin down the priority at that single edge.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;

    // Sizes
    localparam int NSLOT = 16;               // positions per sequence
    localparam int DW    = 12;               // conversion result width
    localparam int BW    = 16;               // register bus data width
    localparam int AW    = 5;                // register bus address width
    localparam int SW    = $clog2(NSLOT);    // position index width

    // Register word addresses; result block aligned to a multiple of NSLOT
    localparam int A_EN    = 0;
    localparam int A_OP    = 1;
    localparam int A_FLG   = 2;
    localparam int A_START = 3;
    localparam int A_RES   = 16;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_EN,
        REG_OP,
        REG_FLG,
        REG_START,
        REG_RES
    } reg_sel_e;

    typedef struct packed {
        logic          valid;
        logic [SW-1:0] slot;
        logic [DW-1:0] data;
    } conv_t;

    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
        int ai;
        ai = int'(a);
        if (ai == A_EN)         return REG_EN;
        else if (ai == A_OP)    return REG_OP;
        else if (ai == A_FLG)   return REG_FLG;
        else if (ai == A_START) return REG_START;
        else if (ai >= A_RES && ai < A_RES + NSLOT) return REG_RES;
        else                    return REG_NONE;
    endfunction

    // op = 1: pass when result above threshold; op = 0: pass when at or below
    function automatic logic cmp_pass(input logic op,
                                      input logic [DW-1:0] res,
                                      input logic [DW-1:0] thr);
        return op ? (res > thr) : (res <= thr);
    endfunction

endpackage

// File: rtl/adc_cmp_ctrl.sv
module adc_cmp_ctrl
    import adc_cmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  reg_sel_e         sel,
    input  logic [BW-1:0]    wdata,
    output logic [NSLOT-1:0] en_q,
    output logic [NSLOT-1:0] op_q,
    output logic             clr_all
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            op_q <= '0;
        end else if (we) begin
            if (sel == REG_EN) en_q <= wdata[NSLOT-1:0];
            if (sel == REG_OP) op_q <= wdata[NSLOT-1:0];
        end
    end

    // sequence-start control: a one in bit 0 wipes the flags
    assign clr_all = we && (sel == REG_START) && wdata[0];

endmodule

// File: rtl/adc_cmp_slot.sv
module adc_cmp_slot
    import adc_cmp_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  conv_t         conv,
    input  logic          en_bit,
    input  logic          op_bit,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] val_q,
    output logic          set_flag
);

    localparam logic [SW-1:0] MY_IDX = SW'(IDX);

    logic hit;
    logic pass;

    assign hit  = conv.valid && (conv.slot == MY_IDX);
    assign pass = cmp_pass(op_bit, conv.data, val_q);

    // a plain store (compare off) has priority over a bus write
    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else if (hit && !en_bit) begin
            val_q <= conv.data;
        end else if (wr_en) begin
            val_q <= wr_data;
        end
    end

    assign set_flag = hit && (!en_bit || pass);

endmodule

// File: rtl/adc_cmp_flags.sv
module adc_cmp_flags
    import adc_cmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic [NSLOT-1:0] set_vec,
    output logic [NSLOT-1:0] flags_q
);

    logic [NSLOT-1:0] kept;

    assign kept = clr_all ? '0 : flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= kept | set_vec;
    end

endmodule

// File: rtl/adc_cmp_unit.sv
module adc_cmp_unit
    import adc_cmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_done,
    input  logic [SW-1:0]    conv_slot,
    input  logic [DW-1:0]    conv_data,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [BW-1:0]    bus_wdata,
    output logic [BW-1:0]    bus_rdata,
    output logic [NSLOT-1:0] cmp_flags
);

    conv_t                      conv;
    reg_sel_e                   sel;
    logic [SW-1:0]              res_idx;
    logic [NSLOT-1:0]           en_q;
    logic [NSLOT-1:0]           op_q;
    logic                       clr_all;
    logic [NSLOT-1:0]           set_vec;
    logic [NSLOT-1:0][DW-1:0]   slot_val;
    logic [BW-1:0]              rd_next;

    assign conv    = '{valid: conv_done, slot: conv_slot, data: conv_data};
    assign sel     = decode_addr(bus_addr);
    assign res_idx = bus_addr[SW-1:0];

    adc_cmp_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_we),
        .sel     (sel),
        .wdata   (bus_wdata),
        .en_q    (en_q),
        .op_q    (op_q),
        .clr_all (clr_all)
    );

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic wr_this;
        assign wr_this = bus_we && (sel == REG_RES) && (res_idx == SW'(i));

        adc_cmp_slot #(.IDX(i)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .conv     (conv),
            .en_bit   (en_q[i]),
            .op_bit   (op_q[i]),
            .wr_en    (wr_this),
            .wr_data  (bus_wdata[DW-1:0]),
            .val_q    (slot_val[i]),
            .set_flag (set_vec[i])
        );
    end

    adc_cmp_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr_all (clr_all),
        .set_vec (set_vec),
        .flags_q (cmp_flags)
    );

    always_comb begin
        unique case (sel)
            REG_EN:  rd_next = BW'(en_q);
            REG_OP:  rd_next = BW'(op_q);
            REG_FLG: rd_next = BW'(cmp_flags);
            REG_RES: rd_next = BW'(slot_val[res_idx]);
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_next;
    end

endmodule

// File: rtl/adc_cmp_chk.sv
module adc_cmp_chk
    import adc_cmp_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     conv_done,
    input logic [SW-1:0]            conv_slot,
    input logic [DW-1:0]            conv_data,
    input logic                     bus_we,
    input logic [AW-1:0]            bus_addr,
    input logic [BW-1:0]            bus_wdata,
    input logic [BW-1:0]            bus_rdata,
    input logic [NSLOT-1:0]         cmp_flags,
    input logic [NSLOT-1:0]         en_q,
    input logic [NSLOT-1:0]         op_q,
    input logic [NSLOT-1:0][DW-1:0] slot_val
);

    logic [SW-1:0] slot_d;
    logic [DW-1:0] data_d;
    logic [DW-1:0] thr_d;
    logic          flag_d;
    logic          start_wr;
    logic          wr_same;
    logic          en_n;
    logic [DW-1:0] thr_n;

    assign en_n     = en_q[conv_slot];
    assign thr_n    = slot_val[conv_slot];
    assign start_wr = bus_we && (int'(bus_addr) == A_START) && bus_wdata[0];
    assign wr_same  = bus_we && (int'(bus_addr) == A_RES + int'(conv_slot));

    always_ff @(posedge clk) begin
        slot_d <= conv_slot;
        data_d <= conv_data;
        thr_d  <= thr_n;
        flag_d <= cmp_flags[conv_slot];
    end

    // R1: flags come out of reset clear
    a_r1_flags_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmp_flags == '0));

    // R2: disabled position stores the result and flags
    a_r2_store_and_flag: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !en_n) |=> (cmp_flags[slot_d] && slot_val[slot_d] == data_d));

    // R3: threshold survives a compared conversion
    a_r3_threshold_kept: assert property (@(posedge clk) disable iff (rst)
        (conv_done && en_n && !wr_same) |=> (slot_val[slot_d] == thr_d));

    // R4: greater-than success
    a_r4_gt_pass: assert property (@(posedge clk) disable iff (rst)
        (conv_done && en_n && op_q[conv_slot] && conv_data > thr_n) |=> cmp_flags[slot_d]);

    // R5: at-or-below success
    a_r5_le_pass: assert property (@(posedge clk) disable iff (rst)
        (conv_done && en_n && !op_q[conv_slot] && !(conv_data > thr_n)) |=> cmp_flags[slot_d]);

    // R6: failed compare holds the flag
    a_r6_fail_holds: assert property (@(posedge clk) disable iff (rst)
        (conv_done && en_n && !start_wr &&
         (op_q[conv_slot] ? !(conv_data > thr_n) : (conv_data > thr_n)))
        |=> (cmp_flags[slot_d] == flag_d));

    // R8: start control clears every flag
    a_r8_start_clears: assert property (@(posedge clk) disable iff (rst)
        (start_wr && !conv_done) |=> (cmp_flags == '0));

    // R9: flag register ignores writes
    a_r9_flag_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_we && int'(bus_addr) == A_FLG && !conv_done) |=> $stable(cmp_flags));

    // R10: flag read returns the flags of the previous cycle
    a_r10_flag_read: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) == A_FLG) |=> (bus_rdata == BW'($past(cmp_flags))));

endmodule

bind adc_cmp_unit adc_cmp_chk u_chk (.*);

// File: tb/tb_adc_cmp_unit.sv
`timescale 1ns/1ps
module tb_adc_cmp_unit;
    import adc_cmp_pkg::*;

    logic             clk = 1'b0;
    logic             rst;
    logic             conv_done;
    logic [SW-1:0]    conv_slot;
    logic [DW-1:0]    conv_data;
    logic             bus_we;
    logic [AW-1:0]    bus_addr;
    logic [BW-1:0]    bus_wdata;
    logic [BW-1:0]    bus_rdata;
    logic [NSLOT-1:0] cmp_flags;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    adc_cmp_unit dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [BW-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(addr); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [BW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(addr);
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic conv(input int slot, input logic [DW-1:0] d);
        @(negedge clk);
        conv_done = 1'b1; conv_slot = SW'(slot); conv_data = d;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [BW-1:0] v;
        chk("R1 flags port", cmp_flags, 0);
        rd(A_EN, v);      chk("R1 enable reg", v, 0);
        rd(A_OP, v);      chk("R1 operator reg", v, 0);
        rd(A_FLG, v);     chk("R1 flag reg", v, 0);
        rd(A_RES + 5, v); chk("R1 result reg 5", v, 0);
    endtask

    task automatic t_disabled();
        logic [BW-1:0] v;
        conv(3, 12'hABC);
        chk("R2 flag 3 set", cmp_flags, 16'h0008);
        rd(A_RES + 3, v); chk("R2 result stored", v, 16'h0ABC);
    endtask

    task automatic t_cmp_gt();
        logic [BW-1:0] v;
        wr(A_START, 16'h0001);
        wr(A_EN, 16'h0020); wr(A_OP, 16'h0020); wr(A_RES + 5, 16'h0400);
        conv(5, 12'h400);
        chk("R6 equal fails above-test", cmp_flags, 0);
        rd(A_RES + 5, v); chk("R3 threshold kept", v, 16'h0400);
        conv(5, 12'h401);
        chk("R4 above sets flag", cmp_flags, 16'h0020);
    endtask

    task automatic t_cmp_le();
        logic [BW-1:0] v;
        wr(A_START, 16'h0001);
        wr(A_EN, 16'h0040); wr(A_OP, 16'h0000); wr(A_RES + 6, 16'h0200);
        conv(6, 12'h201);
        chk("R6 above fails at-or-below", cmp_flags, 0);
        conv(6, 12'h200);
        chk("R5 equal sets flag", cmp_flags, 16'h0040);
        rd(A_RES + 6, v); chk("R3 threshold kept le", v, 16'h0200);
    endtask

    task automatic t_slot_position();
        logic [BW-1:0] v;
        wr(A_START, 16'h0001);
        wr(A_EN, 16'h0080); wr(A_OP, 16'h0000); wr(A_RES + 7, 16'h0100);
        conv(8, 12'hFFF);
        chk("R7 neighbour slot 8 plain", cmp_flags, 16'h0100);
        rd(A_RES + 8, v); chk("R7 slot 8 stored", v, 16'h0FFF);
        conv(7, 12'hFFF);
        chk("R7 slot 7 compared, fails", cmp_flags, 16'h0100);
        rd(A_RES + 7, v); chk("R7 slot 7 threshold", v, 16'h0100);
    endtask

    task automatic t_start();
        wr(A_START, 16'h0000);
        chk("R8 bit0 zero no clear", cmp_flags, 16'h0100);
        wr(A_START, 16'h0001);
        chk("R8 clear all", cmp_flags, 0);
        conv(8, 12'h001);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(A_START); bus_wdata = 16'h0001;
        conv_done = 1'b1; conv_slot = SW'(2); conv_data = 12'h055;
        @(negedge clk);
        bus_we = 1'b0; conv_done = 1'b0;
        chk("R8 same-edge set survives", cmp_flags, 16'h0004);
    endtask

    task automatic t_flag_write();
        logic [BW-1:0] v;
        wr(A_FLG, 16'hFFFF);
        chk("R9 flags port unchanged", cmp_flags, 16'h0004);
        rd(A_FLG, v); chk("R9 flag reg unchanged", v, 16'h0004);
    endtask

    task automatic t_readback();
        logic [BW-1:0] v;
        rd(4, v);     chk("R10 unmapped 4", v, 0);
        rd(A_START, v); chk("R10 start reads zero", v, 0);
        rd(15, v);    chk("R10 unmapped 15", v, 0);
        wr(A_OP, 16'hA5A5);
        rd(A_OP, v);  chk("R10 operator readback", v, 16'hA5A5);
        wr(A_RES + 0, 16'hF123);
        rd(A_RES + 0, v); chk("R10 result truncated", v, 16'h0123);
    endtask

    task automatic t_collision();
        logic [BW-1:0] v;
        wr(A_START, 16'h0001);
        wr(A_EN, 16'h0400); wr(A_OP, 16'h0400); wr(A_RES + 10, 16'h0050);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(A_RES + 9); bus_wdata = 16'h0111;
        conv_done = 1'b1; conv_slot = SW'(9); conv_data = 12'h222;
        @(negedge clk);
        bus_we = 1'b0; conv_done = 1'b0;
        rd(A_RES + 9, v); chk("R11 conversion wins slot 9", v, 16'h0222);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(A_RES + 10); bus_wdata = 16'h0300;
        conv_done = 1'b1; conv_slot = SW'(10); conv_data = 12'h100;
        @(negedge clk);
        bus_we = 1'b0; conv_done = 1'b0;
        chk("R11 old threshold used", cmp_flags, 16'h0600);
        rd(A_RES + 10, v); chk("R11 bus write lands", v, 16'h0300);
    endtask

    initial begin
        rst = 1'b1; conv_done = 1'b0; conv_slot = '0; conv_data = '0;
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disabled();
        t_cmp_gt();
        t_cmp_le();
        t_slot_position();
        t_start();
        t_flag_write();
        t_readback();
        t_collision();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule